// File: doc/BRIEF.md
# OSD horizontal timing generator

This block produces the horizontal timing for an on-screen-display overlay. It runs on the pixel clock and restarts its pixel count on each rising edge of the horizontal sync input. Two settings arrive as plain input ports. A 6-bit line-duration code sets the length of the line, in steps of twelve pixels. An 8-bit display-delay code sets the blank left margin that comes before the first character cell.

The block samples both codes only at the sync edge that opens a line. It then walks the line through four named states:

- `H_WAIT`: idle after reset until the first sync.
- `H_LEAD`: counting through the left margin.
- `H_SHOW`: inside the character window.
- `H_DONE`: saturated at the line length.

The transitions are:

- sync-restart: any state goes to `H_LEAD` on a sync rising edge.
- margin-reached: `H_LEAD` goes to `H_SHOW` when the next count equals the margin.
- line-end: `H_LEAD` or `H_SHOW` goes to `H_DONE` when the next count equals the line length. This check takes priority over margin-reached.

A downstream glyph renderer uses three outputs: the display-active window, the index of the current character cell, and the pixel position inside that 12-pixel cell.

Top module: `osd_htiming`

## Requirements
- R1: After a sync, `pix_cnt` stops at, and never exceeds, the line length (2·LD+1)·12, where LD is `line_dur` read as an unsigned integer.
- R2: For DD ≥ 6, where DD is `disp_delay` read as unsigned, the left margin is 6·DD+18 pixels. This is the same as (DD−6)·6+54.
- R3: For even DD ≤ 6, the left margin is 54 pixels.
- R4: For odd DD ≤ 7, the left margin is 60 pixels.
- R5: At the first clock edge where `hsync` is sampled high after being sampled low, `pix_cnt` becomes 0. Holding `hsync` high does not restart the count again.
- R6: After a sync, `pix_cnt` rises by one per clock until it reaches the line length. It then holds that value until the next sync edge.
- R7: `disp_active` is 1 exactly when margin ≤ `pix_cnt` < line length, and 0 at all other times.
- R8: While `disp_active` is 1, `char_idx` = (`pix_cnt`−margin) div 12 and `char_px` = (`pix_cnt`−margin) mod 12. Both are 0 while `disp_active` is 0.
- R9: `line_dur` and `disp_delay` are used only as sampled at the sync edge. Changing them partway through a line does not alter that line.
- R10: During reset (`rst_n` low, asynchronous) and after it until the first sync edge, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hsync | input | 1 | Horizontal sync; its rising edge starts a line |
| line_dur | input | 6 | Line-duration code LD |
| disp_delay | input | 8 | Display-delay code DD |
| pix_cnt | output | 11 | Pixel position within the line, saturating |
| disp_active | output | 1 | High inside the character window |
| char_idx | output | 7 | Character cell index within the window |
| char_px | output | 4 | Pixel position within the current cell (0..11) |

## Verification
The bench builds the block with its default parameters: a 6-bit duration code, an 8-bit delay code and 12-pixel cells. These give an 11-bit pixel counter. The defaults make the longest line (1524 pixels) and the largest margin (1548 pixels) reachable within a short run, so the case where the margin lies past the line end is exercised. The delay sweep from 0 to 10 crosses both clamp boundaries and the start of the linear region. Short lines, including one whose length equals the margin, reach the case where line-end takes priority over margin-reached.

// File: rtl/osd_htiming_pkg.sv
package osd_htiming_pkg;

    // Line phase of the horizontal walker
    typedef enum logic [1:0] {
        H_WAIT = 2'd0,
        H_LEAD = 2'd1,
        H_SHOW = 2'd2,
        H_DONE = 2'd3
    } hstate_t;

    // Margin floor and offset, counted in half-cell steps
    localparam int EVEN_FLOOR_STEPS = 9;
    localparam int ODD_FLOOR_STEPS  = 10;
    localparam int DELAY_OFFSET     = 3;

endpackage

// File: rtl/osd_hparam_calc.sv
module osd_hparam_calc
    import osd_htiming_pkg::*;
#(
    parameter int LD_W    = 6,
    parameter int DD_W    = 8,
    parameter int CELL_PX = 12,
    parameter int PIX_W   = 11
) (
    input  logic [LD_W-1:0]  line_dur,
    input  logic [DD_W-1:0]  disp_delay,
    output logic [PIX_W-1:0] line_len,
    output logic [PIX_W-1:0] margin
);
    localparam int STEP_PX = CELL_PX / 2;

    logic [PIX_W-1:0] odd_ld;
    logic [PIX_W-1:0] steps;
    logic [PIX_W-1:0] floor_steps;

    always_comb begin
        // Line length: odd multiple of one cell
        odd_ld   = PIX_W'({line_dur, 1'b1});
        line_len = odd_ld * PIX_W'(CELL_PX);

        // Margin in half-cell steps, clamped by delay parity
        floor_steps = disp_delay[0] ? PIX_W'(ODD_FLOOR_STEPS)
                                    : PIX_W'(EVEN_FLOOR_STEPS);
        steps = PIX_W'(disp_delay) + PIX_W'(DELAY_OFFSET);
        if (steps < floor_steps) begin
            steps = floor_steps;
        end
        margin = steps * PIX_W'(STEP_PX);
    end

endmodule

// File: rtl/osd_hline_fsm.sv
module osd_hline_fsm
    import osd_htiming_pkg::*;
#(
    parameter int PIX_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hsync,
    input  logic [PIX_W-1:0] len_in,
    input  logic [PIX_W-1:0] margin_in,
    output logic [PIX_W-1:0] pix_cnt,
    output logic             disp_active,
    output logic             cell_clr,
    output logic             cell_adv
);
    hstate_t          state_q, state_d;
    logic [PIX_W-1:0] pix_q, pix_d, pix_nxt;
    logic [PIX_W-1:0] len_q, marg_q;
    logic             hs_q;
    logic             sync_edge;

    assign sync_edge = hsync & ~hs_q;
    assign pix_nxt   = pix_q + PIX_W'(1);

    // State, counter and line settings register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= H_WAIT;
            pix_q   <= '0;
            len_q   <= '0;
            marg_q  <= '0;
            hs_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            pix_q   <= pix_d;
            hs_q    <= hsync;
            if (sync_edge) begin
                len_q  <= len_in;
                marg_q <= margin_in;
            end
        end
    end

    // Next-state and counter logic
    always_comb begin
        state_d = state_q;
        pix_d   = pix_q;
        if (sync_edge) begin
            state_d = H_LEAD;           // sync-restart
            pix_d   = '0;
        end else begin
            unique case (state_q)
                H_WAIT: begin
                    state_d = H_WAIT;
                end
                H_LEAD: begin
                    pix_d = pix_nxt;
                    if (pix_nxt == len_q) begin
                        state_d = H_DONE;   // line-end wins
                    end else if (pix_nxt == marg_q) begin
                        state_d = H_SHOW;   // margin-reached
                    end
                end
                H_SHOW: begin
                    pix_d = pix_nxt;
                    if (pix_nxt == len_q) begin
                        state_d = H_DONE;   // line-end
                    end
                end
                H_DONE: begin
                    state_d = H_DONE;
                end
            endcase
        end
    end

    // Outputs
    always_comb begin
        pix_cnt     = pix_q;
        disp_active = (state_q == H_SHOW);
        cell_adv    = (state_q == H_SHOW) && (state_d == H_SHOW);
        cell_clr    = sync_edge || ((state_q == H_SHOW) && (state_d != H_SHOW));
    end

    // R5: a sync edge zeroes the counter
    p_sync_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        sync_edge |=> (pix_q == '0));

    // R6: saturated count holds until a new sync
    p_sat_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == H_DONE && !sync_edge) |=> $stable(pix_q));

    // R1: count never passes the line length
    p_len_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != H_WAIT) |-> (pix_q <= len_q));

    // R7: window lies between margin and line end
    p_show_window_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == H_SHOW) |-> (pix_q >= marg_q && pix_q < len_q));

    // R9: settings change only at a sync edge
    p_latch_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !sync_edge |=> ($stable(len_q) && $stable(marg_q)));

    // R10: idle before first sync keeps the counter at zero
    p_wait_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == H_WAIT) |-> (pix_q == '0));

endmodule

// File: rtl/osd_hcell_counter.sv
module osd_hcell_counter #(
    parameter int CELL_PX = 12,
    parameter int PX_W    = 4,
    parameter int IDX_W   = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             adv,
    output logic [IDX_W-1:0] char_idx,
    output logic [PX_W-1:0]  char_px
);
    localparam logic [PX_W-1:0] PX_LAST = PX_W'(CELL_PX - 1);

    logic [IDX_W-1:0] idx_q;
    logic [PX_W-1:0]  px_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q <= '0;
            px_q  <= '0;
        end else if (clr) begin
            idx_q <= '0;
            px_q  <= '0;
        end else if (adv) begin
            if (px_q == PX_LAST) begin
                px_q  <= '0;
                idx_q <= idx_q + IDX_W'(1);
            end else begin
                px_q  <= px_q + PX_W'(1);
            end
        end
    end

    assign char_idx = idx_q;
    assign char_px  = px_q;

    // R8: end of a cell moves to the next one
    p_cell_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !clr && px_q == PX_LAST) |=>
            (px_q == '0 && idx_q == $past(idx_q) + IDX_W'(1)));

    // R8: without advance or clear the cell position holds
    p_cell_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv && !clr) |=> ($stable(px_q) && $stable(idx_q)));

endmodule

// File: rtl/osd_htiming.sv
module osd_htiming
    import osd_htiming_pkg::*;
#(
    parameter int LD_W    = 6,
    parameter int DD_W    = 8,
    parameter int CELL_PX = 12,
    localparam int LEN_MAX  = (2 * (2**LD_W - 1) + 1) * CELL_PX,
    localparam int MARG_MAX = (CELL_PX / 2) * (2**DD_W - 1 + DELAY_OFFSET),
    localparam int PIX_W    = $clog2(((LEN_MAX > MARG_MAX) ? LEN_MAX : MARG_MAX) + 1),
    localparam int IDX_W    = LD_W + 1,
    localparam int PX_W     = $clog2(CELL_PX)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hsync,
    input  logic [LD_W-1:0]  line_dur,
    input  logic [DD_W-1:0]  disp_delay,
    output logic [PIX_W-1:0] pix_cnt,
    output logic             disp_active,
    output logic [IDX_W-1:0] char_idx,
    output logic [PX_W-1:0]  char_px
);
    logic [PIX_W-1:0] line_len;
    logic [PIX_W-1:0] margin;
    logic             cell_clr;
    logic             cell_adv;

    osd_hparam_calc #(
        .LD_W    (LD_W),
        .DD_W    (DD_W),
        .CELL_PX (CELL_PX),
        .PIX_W   (PIX_W)
    ) u_calc (
        .line_dur   (line_dur),
        .disp_delay (disp_delay),
        .line_len   (line_len),
        .margin     (margin)
    );

    osd_hline_fsm #(
        .PIX_W (PIX_W)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .hsync       (hsync),
        .len_in      (line_len),
        .margin_in   (margin),
        .pix_cnt     (pix_cnt),
        .disp_active (disp_active),
        .cell_clr    (cell_clr),
        .cell_adv    (cell_adv)
    );

    osd_hcell_counter #(
        .CELL_PX (CELL_PX),
        .PX_W    (PX_W),
        .IDX_W   (IDX_W)
    ) u_cell (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (cell_clr),
        .adv      (cell_adv),
        .char_idx (char_idx),
        .char_px  (char_px)
    );

    // R8: outside the window the cell outputs rest at zero
    p_cell_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !disp_active |-> (char_idx == '0 && char_px == '0));

endmodule

// File: tb/osd_htiming_test.sv
module osd_htiming_test;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 16;

    // {LD, DD, expected margin, expected line length}
    localparam int VEC [0:NVEC-1][0:3] = '{
        '{5,   0,   54,  132},
        '{5,   1,   60,  132},
        '{5,   2,   54,  132},
        '{5,   3,   60,  132},
        '{6,   4,   54,  156},
        '{6,   5,   60,  156},
        '{7,   6,   54,  180},
        '{7,   7,   60,  180},
        '{8,   8,   66,  204},
        '{8,   9,   72,  204},
        '{9,  10,   78,  228},
        '{0,   0,   54,   12},
        '{2,   1,   60,   60},
        '{2,   0,   54,   60},
        '{63, 255, 1548, 1524},
        '{63, 40,  258, 1524}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hsync = 1'b0;
    logic [5:0]  line_dur = '0;
    logic [7:0]  disp_delay = '0;
    logic [10:0] pix_cnt;
    logic        disp_active;
    logic [6:0]  char_idx;
    logic [3:0]  char_px;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    osd_htiming uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .hsync       (hsync),
        .line_dur    (line_dur),
        .disp_delay  (disp_delay),
        .pix_cnt     (pix_cnt),
        .disp_active (disp_active),
        .char_idx    (char_idx),
        .char_px     (char_px)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic check_idle(input string req);
        check(pix_cnt == 0, req, int'(pix_cnt), 0);
        check(disp_active == 1'b0, req, int'(disp_active), 0);
        check(char_idx == 0, req, int'(char_idx), 0);
        check(char_px == 0, req, int'(char_px), 0);
    endtask

    // One line from sync to saturation; optional settings change at chg_k
    task automatic run_line(input int ld_v, input int dd_v, input int m, input int len,
                            input int chg_k, input int ld2, input int dd2);
        string mt;
        if (dd_v % 2 == 0 && dd_v <= 6)      mt = "R3";
        else if (dd_v % 2 == 1 && dd_v <= 7) mt = "R4";
        else                                 mt = "R2";
        @(negedge clk);
        line_dur   = 6'(ld_v);
        disp_delay = 8'(dd_v);
        hsync      = 1'b1;
        @(negedge clk);
        hsync = 1'b0;
        for (int k = 0; k <= len + 3; k++) begin
            int  ek;
            bit  act;
            int  eidx;
            int  epx;
            ek   = (k < len) ? k : len;
            act  = (k >= m) && (k < len);
            eidx = act ? (k - m) / 12 : 0;
            epx  = act ? (k - m) % 12 : 0;
            if (k < len) check(int'(pix_cnt) == ek, "R6", int'(pix_cnt), ek);
            else         check(int'(pix_cnt) == ek, "R1", int'(pix_cnt), ek);
            if (k == m)  check(disp_active == act, mt, int'(disp_active), int'(act));
            else         check(disp_active == act, "R7", int'(disp_active), int'(act));
            check(int'(char_idx) == eidx, "R8", int'(char_idx), eidx);
            check(int'(char_px) == epx, "R8", int'(char_px), epx);
            if (k == chg_k) begin
                line_dur   = 6'(ld2);
                disp_delay = 8'(dd2);
            end
            @(negedge clk);
        end
    endtask

    initial begin
        // R10: reset state and idle until the first sync
        repeat (3) @(negedge clk);
        check_idle("R10");
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check_idle("R10");

        // Vector table sweep: R1..R4, R6..R8
        for (int i = 0; i < NVEC; i++) begin
            run_line(VEC[i][0], VEC[i][1], VEC[i][2], VEC[i][3], -1, 0, 0);
        end

        // R9: settings changed partway through a line take effect next line
        run_line(5, 0, 54, 132, 20, 0, 10);
        run_line(0, 10, 78, 12, -1, 0, 0);

        // R5: level-held sync does not restart; new edge mid-line does
        @(negedge clk);
        line_dur = 6'd5; disp_delay = 8'd0; hsync = 1'b1;
        @(negedge clk);
        check(pix_cnt == 0, "R5", int'(pix_cnt), 0);
        for (int i = 1; i <= 5; i++) begin
            @(negedge clk);
            check(int'(pix_cnt) == i, "R5", int'(pix_cnt), i);
        end
        hsync = 1'b0;
        repeat (60) @(negedge clk);
        check(pix_cnt == 65, "R6", int'(pix_cnt), 65);
        check(disp_active == 1'b1, "R7", int'(disp_active), 1);
        check(char_idx == 0, "R8", int'(char_idx), 0);
        check(char_px == 11, "R8", int'(char_px), 11);
        @(negedge clk);
        check(char_idx == 1, "R8", int'(char_idx), 1);
        check(char_px == 0, "R8", int'(char_px), 0);
        hsync = 1'b1;
        @(negedge clk);
        hsync = 1'b0;
        check_idle("R5");

        // R10: reset mid-line clears outputs and waits for sync
        repeat (70) @(negedge clk);
        check(disp_active == 1'b1, "R7", int'(disp_active), 1);
        rst_n = 1'b0;
        @(negedge clk);
        check_idle("R10");
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check_idle("R10");

        if (!finished) begin
            finished = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog: got %0d expected %0d", 1, 0);
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule